// File: doc/BRIEF.md
# Prioritised Level Interrupt Controller

This block gathers up to 64 level-sensitive interrupt sources and presents a single request to a processor. Each request carries the number of the winning line and that line's priority. Software controls it through a small register window with doubleword spacing. The enable mask and one control mode bit are never written directly. They change only through a pair of alias addresses: one sets the bits written as 1, and the other clears them. Every line has a 4-bit priority field, and eight fields are packed into each 32-bit priority register.

Each cycle the block forms the pending vector as raw source AND enable. It then picks the eligible line with the largest priority value and registers the result onto the request outputs. A line stays eligible for as long as its source level stays high. A line whose priority is 0 is never chosen. Software can read the raw source levels and the pending vector through two read-only pairs of registers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every enable bit, every priority field and the mode bit are 0, and `irq_req`, `irq_line` and `irq_prio` are 0.
- R2: Writing a word with bit 0 = 1 to offset 0x00 sets the mode bit. Writing a word with bit 0 = 1 to offset 0x08 clears it. Writes with bit 0 = 0 leave the mode bit unchanged. Reads of either offset return the mode bit in bit 0 and zeros elsewhere.
- R3: A write to 0x70 (lines 0–31) or to 0x78 (lines 32–63) sets the enable of each line whose bit is 1, where bit = line mod 32. All other enables are unchanged.
- R4: A write to 0x80 (lines 0–31) or to 0x88 (lines 32–63) clears the enable of each line whose bit is 1 and leaves the others unchanged. Reads of 0x70/0x80 return enables 0–31, and reads of 0x78/0x88 return enables 32–63.
- R5: Priority register k sits at offset 0x10 + 8·k, for k = 0..7. Line i's priority is bits [(i mod 8)·4 +: 4] of register i/8. The registers read back as written.
- R6: 0x50/0x58 return the raw source levels of lines 0–31 and 32–63. 0x60/0x68 return source AND enable for the same line groups. Writes to these four offsets have no effect. Any access with a nonzero address[2:0] writes nothing and reads 0.
- R7: One clock after the state changes, `irq_req` is 1 exactly when some line is pending with a nonzero priority. `irq_line` and `irq_prio` then give the line with the largest priority value and that value.
- R8: Among pending lines that share the largest priority value, the lowest line number wins.
- R9: A pending line with priority 0 never wins. While `irq_req` is 0, `irq_line` and `irq_prio` are 0.
- R10: A request is level-based. It stays asserted while the source stays high and enabled, and it drops one clock after the source falls or the line is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| src_level | input | N_LINES (64) | Level of each interrupt source |
| irq_req | output | 1 | Request to the processor |
| irq_line | output | log2(N_LINES) (6) | Winning line number |
| irq_prio | output | PRIO_W (4) | Priority of the winning line |

## Verification
The bench builds the block with its defaults: 64 lines, 4-bit priorities and 32-bit words. At this size every line, every field position and every priority value can be swept. For each of the 64 lines it tries all 16 priority values on its own, which covers the whole nibble-packing map and the zero-priority exclusion. Tie-breaking and mixed priorities are then covered by hundreds of pseudo-random source, enable and priority patterns, each compared against an arithmetic search for the winner.

// File: rtl/prio_irq_pkg.sv
// Shared register-map constants for the prioritised interrupt controller.
// Offsets are word indices (byte offset / 8). The block ordering is fixed;
// the bases after the priority registers follow from the line count.
package prio_irq_pkg;

    localparam int CTRL_SET_IDX  = 0;
    localparam int CTRL_CLR_IDX  = 1;
    localparam int PRIO_BASE_IDX = 2;

    // Source status block follows the priority registers.
    function automatic int src_base(input int n_prio_regs);
        return PRIO_BASE_IDX + n_prio_regs;
    endfunction

    // Pending status block follows the source status block.
    function automatic int req_base(input int n_prio_regs, input int n_words);
        return src_base(n_prio_regs) + n_words;
    endfunction

    // Enable-set aliases follow the pending status block.
    function automatic int ens_base(input int n_prio_regs, input int n_words);
        return req_base(n_prio_regs, n_words) + n_words;
    endfunction

    // Enable-clear aliases follow the enable-set aliases.
    function automatic int enc_base(input int n_prio_regs, input int n_words);
        return ens_base(n_prio_regs, n_words) + n_words;
    endfunction

endpackage

// File: rtl/irq_regfile.sv
// Writable state of the controller: mode bit, enable mask, priority fields.
// Assumes wr_stb is already qualified by an aligned address. The mode bit and
// enables change only through set/clear aliases; priority words are plain stores.
module irq_regfile
    import prio_irq_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb,
    input  logic [IDX_W-1:0]            widx,
    input  logic [DATA_W-1:0]           wdata,
    output logic                        mode_q,
    output logic [N_LINES-1:0]          en_vec,
    output logic [N_LINES*PRIO_W-1:0]   prio_vec
);
    localparam int N_WORDS     = N_LINES / DATA_W;
    localparam int N_PRIO_REGS = (N_LINES * PRIO_W) / DATA_W;
    localparam int ENS_BASE    = ens_base(N_PRIO_REGS, N_WORDS);
    localparam int ENC_BASE    = enc_base(N_PRIO_REGS, N_WORDS);
    localparam logic [IDX_W-1:0] I_SET = IDX_W'(CTRL_SET_IDX);
    localparam logic [IDX_W-1:0] I_CLR = IDX_W'(CTRL_CLR_IDX);

    // Mode bit: set alias wins over nothing, clear alias clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (wr_stb && wdata[0]) begin
            if (widx == I_SET)
                mode_q <= 1'b1;
            else if (widx == I_CLR)
                mode_q <= 1'b0;
        end
    end

    genvar w;
    generate
        for (w = 0; w < N_WORDS; w++) begin : g_en
            localparam logic [IDX_W-1:0] I_ES = IDX_W'(ENS_BASE + w);
            localparam logic [IDX_W-1:0] I_EC = IDX_W'(ENC_BASE + w);
            // Enable word w: OR in set-alias bits, mask out clear-alias bits.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en_vec[w*DATA_W +: DATA_W] <= '0;
                else if (wr_stb && widx == I_ES)
                    en_vec[w*DATA_W +: DATA_W] <= en_vec[w*DATA_W +: DATA_W] | wdata;
                else if (wr_stb && widx == I_EC)
                    en_vec[w*DATA_W +: DATA_W] <= en_vec[w*DATA_W +: DATA_W] & ~wdata;
            end
        end

        for (w = 0; w < N_PRIO_REGS; w++) begin : g_prio
            localparam logic [IDX_W-1:0] I_PR = IDX_W'(PRIO_BASE_IDX + w);
            // Priority word w: full-word store of eight packed fields.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio_vec[w*DATA_W +: DATA_W] <= '0;
                else if (wr_stb && widx == I_PR)
                    prio_vec[w*DATA_W +: DATA_W] <= wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_readmux.sv
// Combinational read path of the register window.
// Assumes acc_ok flags an aligned access; unaligned or unmapped reads give 0.
// Set and clear aliases both read back the stored value.
module irq_readmux
    import prio_irq_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 5
) (
    input  logic                        acc_ok,
    input  logic [IDX_W-1:0]            widx,
    input  logic                        mode_q,
    input  logic [N_LINES-1:0]          en_vec,
    input  logic [N_LINES*PRIO_W-1:0]   prio_vec,
    input  logic [N_LINES-1:0]          src_vec,
    input  logic [N_LINES-1:0]          pend_vec,
    output logic [DATA_W-1:0]           rdata
);
    localparam int N_WORDS     = N_LINES / DATA_W;
    localparam int N_PRIO_REGS = (N_LINES * PRIO_W) / DATA_W;
    localparam int SRC_BASE    = src_base(N_PRIO_REGS);
    localparam int REQ_BASE    = req_base(N_PRIO_REGS, N_WORDS);
    localparam int ENS_BASE    = ens_base(N_PRIO_REGS, N_WORDS);
    localparam int ENC_BASE    = enc_base(N_PRIO_REGS, N_WORDS);

    // Decode the word index into the selected register value.
    always_comb begin
        rdata = '0;
        if (acc_ok) begin
            if (widx == IDX_W'(CTRL_SET_IDX) || widx == IDX_W'(CTRL_CLR_IDX))
                rdata[0] = mode_q;
            for (int k = 0; k < N_PRIO_REGS; k++)
                if (widx == IDX_W'(PRIO_BASE_IDX + k))
                    rdata = prio_vec[k*DATA_W +: DATA_W];
            for (int w = 0; w < N_WORDS; w++) begin
                if (widx == IDX_W'(SRC_BASE + w))
                    rdata = src_vec[w*DATA_W +: DATA_W];
                if (widx == IDX_W'(REQ_BASE + w))
                    rdata = pend_vec[w*DATA_W +: DATA_W];
                if (widx == IDX_W'(ENS_BASE + w) || widx == IDX_W'(ENC_BASE + w))
                    rdata = en_vec[w*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
// Picks the pending line with the largest nonzero priority.
// Scans from the top line down with >=, so on equal priority the lowest
// line number is kept. Priority 0 is never selected. Purely combinational.
module irq_arbiter #(
    parameter int N_LINES = 64,
    parameter int PRIO_W  = 4,
    parameter int LINE_W  = 6
) (
    input  logic [N_LINES-1:0]          pend_vec,
    input  logic [N_LINES*PRIO_W-1:0]   prio_vec,
    output logic                        found,
    output logic [LINE_W-1:0]           win_line,
    output logic [PRIO_W-1:0]           win_prio
);
    // Linear descending scan over all lines.
    always_comb begin
        win_line = '0;
        win_prio = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend_vec[i] && prio_vec[i*PRIO_W +: PRIO_W] != '0
                && prio_vec[i*PRIO_W +: PRIO_W] >= win_prio) begin
                win_prio = prio_vec[i*PRIO_W +: PRIO_W];
                win_line = LINE_W'(i);
            end
        end
        found = (win_prio != '0);
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the prioritised level interrupt controller.
// Assumes src_level is already synchronous to clk. Pending = source AND
// enable; the arbitration result is registered onto the request outputs,
// so outputs follow state with one clock of latency.
module prio_irq_ctrl #(
    parameter int N_LINES = 64,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [N_LINES-1:0]          src_level,
    output logic                        irq_req,
    output logic [$clog2(N_LINES)-1:0]  irq_line,
    output logic [PRIO_W-1:0]           irq_prio
);
    localparam int LINE_W = $clog2(N_LINES);
    localparam int IDX_W  = ADDR_W - 3;

    logic                       acc_ok;
    logic                       wr_stb;
    logic [IDX_W-1:0]           widx;
    logic                       mode_q;
    logic [N_LINES-1:0]         en_vec;
    logic [N_LINES*PRIO_W-1:0]  prio_vec;
    logic [N_LINES-1:0]         pend_vec;
    logic                       found;
    logic [LINE_W-1:0]          win_line;
    logic [PRIO_W-1:0]          win_prio;

    // Doubleword-aligned accesses only; word index from the upper bits.
    always_comb begin
        acc_ok   = (bus_addr[2:0] == 3'b000);
        wr_stb   = bus_wr && acc_ok;
        widx     = bus_addr[ADDR_W-1:3];
        pend_vec = src_level & en_vec;
    end

    irq_regfile #(
        .N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .widx(widx),
        .wdata(bus_wdata), .mode_q(mode_q), .en_vec(en_vec), .prio_vec(prio_vec)
    );

    irq_readmux #(
        .N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_rd (
        .acc_ok(acc_ok), .widx(widx), .mode_q(mode_q), .en_vec(en_vec),
        .prio_vec(prio_vec), .src_vec(src_level), .pend_vec(pend_vec),
        .rdata(bus_rdata)
    );

    irq_arbiter #(
        .N_LINES(N_LINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W)
    ) u_arb (
        .pend_vec(pend_vec), .prio_vec(prio_vec), .found(found),
        .win_line(win_line), .win_prio(win_prio)
    );

    // Register the arbitration result toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req  <= 1'b0;
            irq_line <= '0;
            irq_prio <= '0;
        end else begin
            irq_req  <= found;
            irq_line <= win_line;
            irq_prio <= win_prio;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Property checker for prio_irq_ctrl, attached by bind below.
// Observes the bus, the request outputs and the stored enable/priority state.
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int PRIO_W  = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        irq_req,
    input  logic [$clog2(N_LINES)-1:0]  irq_line,
    input  logic [PRIO_W-1:0]           irq_prio,
    input  logic                        mode_q,
    input  logic [N_LINES-1:0]          en_vec,
    input  logic [N_LINES*PRIO_W-1:0]   prio_vec,
    input  logic [N_LINES-1:0]          pend_vec
);
    localparam int N_WORDS     = N_LINES / DATA_W;
    localparam int N_PRIO_REGS = (N_LINES * PRIO_W) / DATA_W;
    localparam int IDX_W       = ADDR_W - 3;
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(CTRL_SET_IDX * 8);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CTRL_CLR_IDX * 8);
    localparam logic [ADDR_W-1:0] A_ES0 = ADDR_W'(ens_base(N_PRIO_REGS, N_WORDS) * 8);
    localparam logic [ADDR_W-1:0] A_EC0 = ADDR_W'(enc_base(N_PRIO_REGS, N_WORDS) * 8);

    logic [N_LINES-1:0]         prev_pend;
    logic [N_LINES*PRIO_W-1:0]  prev_prio;

    // Hold last cycle's pending vector and priorities for the output checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_pend <= '0;
            prev_prio <= '0;
        end else begin
            prev_pend <= pend_vec;
            prev_prio <= prio_vec;
        end
    end

    assert_mode_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SET && bus_wdata[0]) |=> mode_q);

    assert_mode_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR && bus_wdata[0]) |=> !mode_q);

    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ES0)
        |=> ((en_vec[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EC0)
        |=> ((en_vec[DATA_W-1:0] & $past(bus_wdata)) == '0));

    assert_winner_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> prev_pend[irq_line]);

    assert_winner_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio == prev_prio[irq_line*PRIO_W +: PRIO_W]));

    assert_nonzero_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio != '0));

    assert_idle_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_line == '0 && irq_prio == '0));

    assert_level_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec == '0) |=> !irq_req);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .N_LINES(N_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_req(irq_req), .irq_line(irq_line),
    .irq_prio(irq_prio), .mode_q(mode_q), .en_vec(en_vec),
    .prio_vec(prio_vec), .pend_vec(pend_vec)
);

// File: tb/sim_prio_irq_ctrl.sv
// Self-checking bench: register map sweeps, single-line priority sweep,
// pseudo-random arbitration patterns checked against an arithmetic model.
module sim_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_level = '0;
    logic        irq_req;
    logic [5:0]  irq_line;
    logic [3:0]  irq_prio;

    int checks = 0;
    int errors = 0;

    logic [63:0] en_m = '0;
    logic [3:0]  pr_m [64];
    logic        mode_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_level(src_level),
        .irq_req(irq_req), .irq_line(irq_line), .irq_prio(irq_prio)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] prio_word(input int k);
        logic [31:0] w = '0;
        for (int j = 0; j < 8; j++) w[j*4 +: 4] = pr_m[k*8 + j];
        return w;
    endfunction

    task automatic push_prio(input int k);
        bus_write(8'(8'h10 + 8*k), prio_word(k));
    endtask

    // Expected arbitration result from the requirement text.
    task automatic chk_arb(input string req);
        logic [63:0] pend;
        int bl;
        int bp;
        pend = src_level & en_m;
        bl = 0; bp = 0;
        for (int i = 0; i < 64; i++)
            if (pend[i] && pr_m[i] > 4'(bp)) begin bp = pr_m[i]; bl = i; end
        settle();
        chk(irq_req == (bp != 0), req, "irq_req", 64'(irq_req), 64'(bp != 0));
        chk(irq_line == 6'(bl), req, "irq_line", 64'(irq_line), 64'(bl));
        chk(irq_prio == 4'(bp), req, "irq_prio", 64'(irq_prio), 64'(bp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] rd2;
        logic [31:0] m;
        for (int i = 0; i < 64; i++) pr_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state across the whole window
        for (int a = 0; a < 18; a++) begin
            bus_read(8'(a*8), rd);
            chk(rd == 32'h0, "R1", "reset read", 64'(rd), 64'h0);
        end
        chk(irq_req == 1'b0 && irq_line == 6'd0 && irq_prio == 4'd0, "R1",
            "reset outputs", {54'b0, irq_req, irq_line, irq_prio}, 64'h0);

        // R2: mode bit via aliases
        bus_write(8'h00, 32'hFFFF_FFFE);
        bus_read(8'h00, rd);
        chk(rd == 32'h0, "R2", "set alias bit0=0", 64'(rd), 64'h0);
        bus_write(8'h00, 32'h1);
        bus_read(8'h00, rd); bus_read(8'h08, rd2);
        chk(rd == 32'h1 && rd2 == 32'h1, "R2", "mode set", {rd, rd2}, {32'h1, 32'h1});
        bus_write(8'h08, 32'hFFFF_FFFE);
        bus_read(8'h08, rd);
        chk(rd == 32'h1, "R2", "clear alias bit0=0", 64'(rd), 64'h1);
        bus_write(8'h08, 32'h1);
        bus_read(8'h00, rd);
        chk(rd == 32'h0, "R2", "mode clear", 64'(rd), 64'h0);

        // R3/R4: walking single-line set and clear
        for (int i = 0; i < 64; i++) begin
            bus_write(i < 32 ? 8'h70 : 8'h78, 32'h1 << (i % 32));
            bus_read(i < 32 ? 8'h80 : 8'h88, rd);
            chk(rd == (32'h1 << (i % 32)), "R3", "walking set", 64'(rd), 64'(32'h1 << (i % 32)));
            bus_write(i < 32 ? 8'h80 : 8'h88, 32'h1 << (i % 32));
            bus_read(i < 32 ? 8'h70 : 8'h78, rd);
            chk(rd == 32'h0, "R4", "walking clear", 64'(rd), 64'h0);
        end
        bus_write(8'h70, 32'hA5A5_0F0F);
        bus_write(8'h70, 32'h1200_0030);
        bus_read(8'h70, rd);
        chk(rd == 32'hB7A5_0F3F, "R3", "set accumulates", 64'(rd), 64'hB7A5_0F3F);
        bus_read(8'h78, rd);
        chk(rd == 32'h0, "R3", "upper word untouched", 64'(rd), 64'h0);
        bus_write(8'h80, 32'h0000_FFFF);
        bus_read(8'h80, rd);
        chk(rd == 32'hB7A5_0000, "R4", "partial clear", 64'(rd), 64'hB7A5_0000);
        bus_write(8'h78, 32'hFFFF_FFFF);
        bus_write(8'h80, 32'hFFFF_FFFF);
        bus_write(8'h88, 32'hFFFF_FFFF);
        bus_read(8'h70, rd); bus_read(8'h78, rd2);
        chk(rd == 32'h0 && rd2 == 32'h0, "R4", "disable all", {rd, rd2}, 64'h0);

        // R5: priority registers read back
        for (int k = 0; k < 8; k++) begin
            m = 32'h1357_9BDF ^ (32'h1111_1111 * 32'(k));
            bus_write(8'(8'h10 + 8*k), m);
            bus_read(8'(8'h10 + 8*k), rd);
            chk(rd == m, "R5", "priority readback", 64'(rd), 64'(m));
        end
        for (int k = 0; k < 8; k++) bus_write(8'(8'h10 + 8*k), 32'h0);

        // R6: status views, read-only, and unaligned accesses
        bus_write(8'h70, 32'h0000_FF00); en_m[31:0] = 32'h0000_FF00;
        bus_write(8'h78, 32'hF000_0001); en_m[63:32] = 32'hF000_0001;
        src_level = 64'h3000_0003_0000_3C3C;
        bus_read(8'h50, rd); bus_read(8'h58, rd2);
        chk({rd2, rd} == src_level, "R6", "source view", {rd2, rd}, src_level);
        bus_read(8'h60, rd); bus_read(8'h68, rd2);
        chk({rd2, rd} == (src_level & en_m), "R6", "pending view", {rd2, rd}, src_level & en_m);
        bus_write(8'h60, 32'hFFFF_FFFF);
        bus_write(8'h50, 32'hFFFF_FFFF);
        bus_read(8'h70, rd); bus_read(8'h60, rd2);
        chk(rd == 32'h0000_FF00 && rd2 == 32'h0000_3C00, "R6", "status write ignored",
            {rd, rd2}, {32'h0000_FF00, 32'h0000_3C00});
        bus_write(8'h71, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'h1);
        bus_read(8'h70, rd);
        chk(rd == 32'h0000_FF00, "R6", "unaligned write ignored", 64'(rd), 64'h0000_FF00);
        bus_read(8'h00, rd);
        chk(rd == 32'h0, "R6", "unaligned mode write ignored", 64'(rd), 64'h0);
        bus_read(8'h72, rd);
        chk(rd == 32'h0, "R6", "unaligned read zero", 64'(rd), 64'h0);
        chk_arb("R9");

        // R7/R9/R5: each line alone with every priority value
        bus_write(8'h70, 32'hFFFF_FFFF);
        bus_write(8'h78, 32'hFFFF_FFFF);
        en_m = '1;
        for (int l = 0; l < 64; l++) begin
            src_level = 64'h1 << l;
            for (int p = 0; p < 16; p++) begin
                pr_m[l] = 4'(p);
                push_prio(l / 8);
                chk_arb(p == 0 ? "R9" : "R7");
            end
            pr_m[l] = 4'h0;
            push_prio(l / 8);
        end

        // R8: equal priority everywhere, lowest pending line wins
        for (int i = 0; i < 64; i++) pr_m[i] = 4'h7;
        for (int k = 0; k < 8; k++) push_prio(k);
        for (int t = 0; t < 40; t++) begin
            src_level = {$urandom(), $urandom()} & ~((64'h1 << (t % 60)) - 64'h1);
            chk_arb("R8");
        end

        // R7/R8: random priorities, sources and enables
        for (int t = 0; t < 150; t++) begin
            if (t % 10 == 0) begin
                for (int i = 0; i < 64; i++) pr_m[i] = 4'($urandom_range(0, 15) & 32'(t % 3 == 0 ? 4'h3 : 4'hF));
                for (int k = 0; k < 8; k++) push_prio(k);
                m = $urandom();
                bus_write(8'h70, m); en_m[31:0] = en_m[31:0] | m;
                m = $urandom();
                bus_write(8'h88, m); en_m[63:32] = en_m[63:32] & ~m;
            end
            src_level = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            chk_arb("R7");
        end

        // R10: level behaviour, source fall and disable
        for (int i = 0; i < 64; i++) pr_m[i] = 4'h0;
        for (int k = 0; k < 8; k++) push_prio(k);
        pr_m[45] = 4'h9; push_prio(5);
        bus_write(8'h78, 32'h1 << 13); en_m[45] = 1'b1;
        src_level = 64'h1 << 45;
        chk_arb("R10");
        repeat (5) begin
            @(negedge clk);
            chk(irq_req && irq_line == 6'd45, "R10", "held while high",
                {57'b0, irq_req, irq_line}, {57'b0, 1'b1, 6'd45});
        end
        src_level = '0;
        @(negedge clk);
        chk(irq_req == 1'b0, "R10", "drop after source fall", 64'(irq_req), 64'h0);
        src_level = 64'h1 << 45;
        chk_arb("R10");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h88; bus_wdata = 32'h1 << 13;
        @(negedge clk);
        bus_wr = 1'b0; en_m[45] = 1'b0;
        chk(irq_req == 1'b1, "R10", "still set same cycle as disable", 64'(irq_req), 64'h1);
        @(negedge clk);
        chk(irq_req == 1'b0, "R10", "drop after disable", 64'(irq_req), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule